// File: doc/BRIEF.md
# Interconnect Test Response Chain

This block is a row of built-in test cells for routing wires that are checked in groups of four. Each cell has three parts. A pattern generator drives its group from a shared test-select code. A wire-group model carries the four driven bits to the far end, and optional per-wire fault injection can corrupt them there. A response checker at the far end judges the received word. The cells are linked by a clocked fail chain that carries failures toward a single chain-end output, one position per clock.

A start pulse clears the chain and restarts a slot counter. Positions are counted from the chain end: the cell beside the output is position 0. A failing cell may load its failure into the chain only in its own slot, which is the cycle in which the counter equals its position. The failure then travels to the output. A controller outside the block therefore learns a failing cell's position from the cycle in which `chain_end_o` goes high. It learns the fault class by repeating the run with each test-select code.

Each group is flanked by two guard wires. Each guard is driven opposite to the group wire next to it, so that a short across the group edge is visible. The guards are never fed to the checker.

Top module: `ict_ora_chain`

## Requirements
- R1: `test_sel_i` selects the word driven onto wires 1 to 4, with wire 1 as the most significant bit:
  - codes 0, 1, 2 and 3 select the basic words 0000, 1111, 1010 and 0101;
  - codes 4, 5, 6 and 7 select the refinement words 1110, 0111, 1000 and 0001.
- R2: The guard beside wire 1 is driven to the inverse of wire 1, and the guard beside wire 4 to the inverse of wire 4. A short from wire 4 to its guard therefore shows under words where wire 4 is 1, and hides where wire 4 is 0.
- R3: A checker reports pass only when its received word is 0000, 1111, 1010 or 0101. Every other word is a fail, so a fault-free group fails under each refinement word.
- R4: Each cell has an 8-bit fault field in `fault_i[p*8 +: 8]`, where p is the cell's position. Wire w (1 to 4) has a 2-bit code at bits [(w-1)*2 +: 2] of that field. Code 0 means no fault. Code 1 forces the received wire to 0 and code 2 forces it to 1.
- R5: Code 3 shorts wire w to its neighbour on the wire-4 side; wire 4's neighbour is its right guard. Both shorted wires then carry the AND of their driven values. A stuck code on a wire overrides the short on that wire.
- R6: A cell at position p may load its failure only in the cycle when the slot counter equals p. The counter counts cycles since the start pulse, so no two cells ever load in the same cycle.
- R7: A failure loaded at position p reaches `chain_end_o` in cycle 2p+1 after the start edge (cycle 0 follows that edge). It stays high there for exactly one cycle, so `chain_end_o` is never high in two consecutive cycles.
- R8: `start_i` clears every chain stage and restarts the slot counter. A restart in mid-run discards failures that are still travelling.
- R9: After reset the counter rests in an idle state with no open slots, so no failure enters the chain until the first start pulse.
- R10: When several cells fail in the same run, each one gives its own pulse in its own cycle on `chain_end_o`.
- R11: A cell that is not loading in a cycle passes the value from upstream on unchanged. A failure from the far end of the row therefore crosses every passing cell.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that clears the chain and restarts the slot counter |
| test_sel_i | input | 3 | Shared pattern select for every generator |
| fault_i | input | CELLS*8 | Per-wire fault codes, 8 bits per cell |
| chain_end_o | output | 1 | Fail chain output at position 0 |

## Verification
The bound checker watches, on every cycle, that:
- at most one cell loads the chain in any cycle;
- a start pulse leaves the chain empty on the next cycle;
- each stage that is not loading copies its upstream neighbour;
- a fault-free group never fails under a basic word;
- the chain end never stays high for two cycles in a row.

Only the bench's scenarios show the rest. These are the actual meaning of each selected word and its guards, and the effect of each stuck and short code. They also cover the exact arrival cycle that encodes a cell's position, the idle state after reset, and the loss of in-flight failures on a restart. The bench sweeps every code, cell, wire and fault kind on a four-cell row, then runs pseudo-random mixtures of faults.

// File: rtl/ict_pkg.sv
package ict_pkg;

  // Per-wire fault code
  typedef enum logic [1:0] {
    FLT_NONE = 2'd0,
    FLT_SA0  = 2'd1,
    FLT_SA1  = 2'd2,
    FLT_BRG  = 2'd3
  } flt_e;

  localparam int SEL_W    = 3;
  localparam int FLT_BITS = 8;

  // Word placed on wires 1..4 (wire 1 is bit 3)
  function automatic logic [3:0] vec_of(input logic [SEL_W-1:0] sel);
    logic [3:0] v;
    case (sel)
      3'd0:    v = 4'b0000;
      3'd1:    v = 4'b1111;
      3'd2:    v = 4'b1010;
      3'd3:    v = 4'b0101;
      3'd4:    v = 4'b1110;
      3'd5:    v = 4'b0111;
      3'd6:    v = 4'b1000;
      default: v = 4'b0001;
    endcase
    return v;
  endfunction

  // Six driven lines: index 5 left guard, 4..1 wires 1..4, 0 right guard
  function automatic logic [5:0] drive_of(input logic [3:0] v);
    return {~v[3], v, ~v[0]};
  endfunction

  function automatic logic is_basic(input logic [3:0] w);
    return (w == 4'b0000) || (w == 4'b1111) || (w == 4'b1010) || (w == 4'b0101);
  endfunction

  // Received word after fault injection; a bridge at index i shorts i and i-1
  function automatic logic [3:0] observe(input logic [5:0] drv, input logic [FLT_BITS-1:0] flt);
    logic [5:1] brg;
    logic [3:0] obs;
    logic       b;
    logic [1:0] code;
    brg = '0;
    for (int w = 0; w < 4; w++) begin
      brg[4-w] = (flt[w*2 +: 2] == FLT_BRG);
    end
    obs = '0;
    for (int i = 1; i <= 4; i++) begin
      b = drv[i];
      if (brg[i])   b = b & drv[i-1];
      if (brg[i+1]) b = b & drv[i+1];
      code = flt[(4-i)*2 +: 2];
      if (code == FLT_SA0)      b = 1'b0;
      else if (code == FLT_SA1) b = 1'b1;
      obs[i-1] = b;
    end
    return obs;
  endfunction

endpackage

// File: rtl/ict_vector_gen.sv
module ict_vector_gen
  import ict_pkg::*;
(
  input  logic [SEL_W-1:0] sel_i,
  output logic [5:0]       drive_o
);
  logic [3:0] word;

  assign word    = vec_of(sel_i);
  assign drive_o = drive_of(word);
endmodule

// File: rtl/ict_wire_group.sv
module ict_wire_group
  import ict_pkg::*;
(
  input  logic [5:0]          drive_i,
  input  logic [FLT_BITS-1:0] fault_i,
  output logic [3:0]          obs_o
);
  assign obs_o = observe(drive_i, fault_i);
endmodule

// File: rtl/ict_resp_check.sv
module ict_resp_check
  import ict_pkg::*;
(
  input  logic [3:0] obs_i,
  output logic       fail_o
);
  assign fail_o = ~is_basic(obs_i);
endmodule

// File: rtl/ict_slot_timer.sv
module ict_slot_timer #(
  parameter int CELLS = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output logic [CELLS-1:0] slot_o
);
  localparam int LAST = 2 * CELLS;
  localparam int CW   = $clog2(LAST + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= CW'(LAST);
    else if (start_i)            cnt_q <= '0;
    else if (cnt_q != CW'(LAST)) cnt_q <= cnt_q + 1'b1;
  end

  for (genvar p = 0; p < CELLS; p++) begin : g_slot
    assign slot_o[p] = (cnt_q == CW'(p));
  end
endmodule

// File: rtl/ict_ora_chain.sv
module ict_ora_chain
  import ict_pkg::*;
#(
  parameter int CELLS = 8,
  localparam int FW   = CELLS * FLT_BITS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SEL_W-1:0] test_sel_i,
  input  logic [FW-1:0]    fault_i,
  output logic             chain_end_o
);
  logic [CELLS-1:0] slot;
  logic [CELLS-1:0] cell_fail;
  logic [CELLS-1:0] inject;
  logic [CELLS-1:0] chain_up;
  logic [CELLS-1:0] chain_q;

  ict_slot_timer #(.CELLS(CELLS)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .slot_o (slot)
  );

  for (genvar p = 0; p < CELLS; p++) begin : g_cell
    logic [5:0] drive;
    logic [3:0] obs;

    ict_vector_gen u_gen (
      .sel_i  (test_sel_i),
      .drive_o(drive)
    );

    ict_wire_group u_grp (
      .drive_i(drive),
      .fault_i(fault_i[p*FLT_BITS +: FLT_BITS]),
      .obs_o  (obs)
    );

    ict_resp_check u_chk (
      .obs_i (obs),
      .fail_o(cell_fail[p])
    );

    assign inject[p] = slot[p] & cell_fail[p];

    if (p == CELLS - 1) begin : g_head
      assign chain_up[p] = 1'b0;
    end else begin : g_link
      assign chain_up[p] = chain_q[p+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      chain_q <= '0;
    else if (start_i) chain_q <= '0;
    else              chain_q <= chain_up | inject;
  end

  assign chain_end_o = chain_q[0];
endmodule

// File: rtl/ict_ora_chain_chk.sv
module ict_ora_chain_chk #(
  parameter int CELLS = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic [2:0]         test_sel_i,
  input logic [CELLS*8-1:0] fault_i,
  input logic [CELLS-1:0]   cell_fail,
  input logic [CELLS-1:0]   inject,
  input logic [CELLS-1:0]   chain_up,
  input logic [CELLS-1:0]   chain_q,
  input logic               chain_end_o
);
  assert_one_slot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(inject))
    else $error("R6: two cells loaded the chain in one cycle");

  assert_start_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (chain_q == '0))
    else $error("R8: chain not empty after start");

  assert_single_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chain_end_o |=> !chain_end_o)
    else $error("R7: chain end high on consecutive cycles");

  for (genvar p = 0; p < CELLS; p++) begin : g_cell_chk
    assert_pass_through_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!start_i && !inject[p]) |=> (chain_q[p] == $past(chain_up[p])))
      else $error("R11: stage %0d altered upstream value", p);

    assert_clean_pass_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((fault_i[p*8 +: 8] == 8'h00) && !test_sel_i[2]) |-> !cell_fail[p])
      else $error("R3: fault-free cell %0d failed a basic word", p);
  end
endmodule

bind ict_ora_chain ict_ora_chain_chk #(.CELLS(CELLS)) u_ict_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .test_sel_i (test_sel_i),
  .fault_i    (fault_i),
  .cell_fail  (cell_fail),
  .inject     (inject),
  .chain_up   (chain_up),
  .chain_q    (chain_q),
  .chain_end_o(chain_end_o)
);

// File: tb/ict_ora_chain_tb.sv
`timescale 1ns/1ps
module ict_ora_chain_tb;
  localparam int M  = 4;
  localparam int FW = M * 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [2:0]    sel = '0;
  logic [FW-1:0] flt = '0;
  logic          chain_end;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ict_ora_chain #(.CELLS(M)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .start_i    (start),
    .test_sel_i (sel),
    .fault_i    (flt),
    .chain_end_o(chain_end)
  );

  // Independent model: d[0] left guard, d[1..4] wires 1..4, d[5] right guard
  function automatic bit cell_fails(input logic [2:0] s, input logic [7:0] f);
    bit d[0:5];
    bit o[1:4];
    int code[1:5];
    int word;
    int v;
    v = (s == 0) ? 0 : (s == 1) ? 15 : (s == 2) ? 10 : (s == 3) ? 5 :
        (s == 4) ? 14 : (s == 5) ? 7 : (s == 6) ? 8 : 1;
    for (int w = 1; w <= 4; w++) d[w] = ((v >> (4 - w)) & 1) != 0;
    d[0] = !d[1];
    d[5] = !d[4];
    for (int w = 1; w <= 4; w++) code[w] = int'(f[(w-1)*2 +: 2]);
    code[5] = 0;
    word = 0;
    for (int w = 1; w <= 4; w++) begin
      o[w] = d[w];
      if (code[w] == 3) o[w] = o[w] && d[w+1];
      if (w > 1 && code[w-1] == 3) o[w] = o[w] && d[w-1];
      if (code[w] == 1) o[w] = 1'b0;
      if (code[w] == 2) o[w] = 1'b1;
      word = word * 2 + int'(o[w]);
    end
    return !(word == 0 || word == 15 || word == 10 || word == 5);
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input int c);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cycle %0d: chain_end actual=%b expected=%b", req, c, act, exp);
    end
  endtask

  task automatic run_case(input string req, input logic [2:0] s, input logic [FW-1:0] f);
    bit exp[M];
    logic e;
    for (int p = 0; p < M; p++) exp[p] = cell_fails(s, f[p*8 +: 8]);
    @(negedge clk);
    sel = s;
    flt = f;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= 2 * M; c++) begin
      if (c > 0) @(negedge clk);
      e = 1'b0;
      if ((c % 2) == 1) e = exp[(c - 1) / 2];
      check(req, chain_end, e, c);
    end
  endtask

  function automatic logic [FW-1:0] one_fault(input int p, input int w, input logic [1:0] code);
    logic [FW-1:0] f;
    f = '0;
    f[p*8 + (w-1)*2 +: 2] = code;
    return f;
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    int unsigned seed;
    logic [FW-1:0] f;

    // R9: reset holds chain clear
    sel = 3'd4;
    flt = '0;
    repeat (3) @(negedge clk);
    check("R9", chain_end, 1'b0, 0);
    rst_n = 1'b1;
    // R9: no start yet, every cell fails under word 1110, yet nothing enters
    for (int c = 0; c < 2 * M + 2; c++) begin
      @(negedge clk);
      check("R9", chain_end, 1'b0, c);
    end

    // R3: basic words on clean groups pass
    for (int s = 0; s < 4; s++) run_case("R3", 3'(s), '0);
    // R1, R3: refinement words fail on clean groups
    for (int s = 4; s < 8; s++) run_case("R1", 3'(s), '0);
    // R1: 1110 with wire 4 stuck at 1 becomes 1111 and passes
    run_case("R1", 3'd4, one_fault(2, 4, 2'd2));
    run_case("R1", 3'd5, one_fault(1, 1, 2'd2));
    // R4: stuck codes
    run_case("R4", 3'd1, one_fault(0, 3, 2'd1));
    run_case("R4", 3'd0, one_fault(3, 2, 2'd2));
    // R2: wire 4 shorted to its guard
    for (int s = 0; s < 4; s++) run_case("R2", 3'(s), one_fault(1, 4, 2'd3));
    // R5: wire 2 shorted to wire 3
    run_case("R5", 3'd2, one_fault(3, 2, 2'd3));
    run_case("R5", 3'd0, one_fault(3, 2, 2'd3));
    // R11: failure from the head cell crosses all passing cells
    run_case("R11", 3'd0, one_fault(M - 1, 1, 2'd2));
    // R10: two cells fail together
    run_case("R10", 3'd1, one_fault(0, 1, 2'd1) | one_fault(2, 4, 2'd1));

    // R8: restart in mid-run drops a travelling failure
    @(negedge clk);
    sel = 3'd0;
    flt = one_fault(3, 1, 2'd2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 5; c++) begin
      if (c > 0) @(negedge clk);
      check("R8", chain_end, 1'b0, c);
    end
    @(negedge clk);
    flt = '0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c <= 2 * M + 1; c++) begin
      if (c > 0) @(negedge clk);
      check("R8", chain_end, 1'b0, c);
    end

    // R6, R7: every word, cell, wire and fault kind
    for (int s = 0; s < 8; s++)
      for (int p = 0; p < M; p++)
        for (int w = 1; w <= 4; w++)
          for (int k = 1; k <= 3; k++)
            run_case("R7", 3'(s), one_fault(p, w, 2'(k)));

    // R10: pseudo-random fault mixtures
    seed = 32'h1234_5678;
    for (int n = 0; n < 200; n++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      f = FW'(seed);
      seed = seed * 32'd1103515245 + 32'd12345;
      run_case("R10", 3'(seed >> 16), f);
    end

    done = 1'b1;
    finish_run();
  end
endmodule